// File: doc/BRIEF.md
# Synchronous burst SRAM cycle controller

This block is the clocked control core of a synchronous burst static RAM. On every rising clock edge it samples three chip enables, a processor-side and a controller-side address strobe, an advance input, and the write controls (global write, byte-write enable and one enable per byte). From these it classifies the cycle as one of four kinds:

- a deselect;
- a burst start at the external address;
- a burst continue at the next address;
- a burst suspend at the current address.

It then drives the strobes, the address and the byte mask of a small on-block memory array.

A 2-bit burst counter holds the low address bits. It steps in linear order, modulo 4, while the upper address bits stay fixed. Read data is registered and appears one clock after the read cycle is accepted. The data bus drive enable is gated without a clock by an active-low output enable, so a change on that pin shows up without waiting for an edge.

A sleep input takes priority over every other input. While sleep is high, all other inputs are ignored and the bus is released. After sleep falls, the block waits a fixed recovery time before it accepts a new cycle.

Top module: `sburst_ctrl`

## Requirements
- R1: The write request is active when `gw_ni` is 0, or when `bwe_ni` is 0 and at least one bit of `bw_ni` is 0. It is inactive in every other case, including `bwe_ni`=1 with all bytes enabled. With `gw_ni`=0 every byte is written. Otherwise byte b is written only if `bw_ni[b]`=0. Byte b is `data[8b+7:8b]`. Write data is sampled at the same edge as the write cycle.
- R2: With `ce1_ni`=1 the processor strobe is ignored. If `strb_ctl_ni`=0 in that state, the cycle is a deselect: the burst ends and the bus is released.
- R3: With `ce1_ni`=0 and `strb_cpu_ni`=0, the cycle is a deselect when `ce2_i`=0 or `ce3_ni`=1. The current burst ends.
- R4: A processor-strobe start (`ce1_ni`=0, `ce2_i`=1, `ce3_ni`=0, `strb_cpu_ni`=0) is always a read at `addr_i`, whatever the write controls are. The clocks that follow it may write.
- R5: A controller-strobe start (`strb_cpu_ni`=1 or ignored, `strb_ctl_ni`=0, `ce1_ni`=0, `ce2_i`=1, `ce3_ni`=0) begins a burst at `addr_i`. It writes or reads according to the write request. If `ce2_i`=0 or `ce3_ni`=1, the cycle is a deselect and no write takes place.
- R6: A continue cycle needs both strobes high, or `ce1_ni`=1 with `strb_ctl_ni`=1, together with `adv_ni`=0 and an active burst. It accesses the next address: the low two bits are incremented modulo 4 (for example 0x0E, 0x0F, 0x0C, 0x0D) and the upper bits are kept. The write request selects a read or a write.
- R7: The same conditions with `adv_ni`=1 give a suspend, which accesses the current address again. The write request selects a read or a write.
- R8: Read data is valid on `rdata_o` after the edge that accepts the read. `data_oe_o` is 1 only after an accepted read, with `oe_ni`=0 and `sleep_i`=0. `data_oe_o` follows `oe_ni` without waiting for a clock. It is 0 after write, deselect and idle cycles.
- R9: While `sleep_i`=1, all other inputs are ignored, no array access happens, `data_oe_o`=0 and any active burst is abandoned. The first two edges after `sleep_i` falls are also ignored. The third edge is accepted.
- R10: Continue or suspend conditions with no active burst (after reset, a deselect or sleep) cause no access, and `data_oe_o` stays 0.
- R11: After reset, `data_oe_o` is 0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce1_ni | input | 1 | Primary chip enable, active low |
| ce2_i | input | 1 | Second chip enable, active high |
| ce3_ni | input | 1 | Third chip enable, active low |
| strb_cpu_ni | input | 1 | Processor-side address strobe, active low |
| strb_ctl_ni | input | 1 | Controller-side address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| gw_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte-write enable, active low |
| bw_ni | input | DW/BW | Per-byte write enables, active low |
| sleep_i | input | 1 | Sleep request, active high |
| oe_ni | input | 1 | Output enable, active low, not clocked |
| addr_i | input | AW | External address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Registered read data |
| data_oe_o | output | 1 | Data bus drive enable |

## Verification
The assertions assume that all control inputs are free of X/Z and are stable around each rising edge. They also assume that write data comes with its write cycle, and that `sleep_i` is a level seen at clock edges, so a sleep request shorter than one clock does not count as a recovery. The bench changes every input on the falling edge and checks outputs on the next falling edge. `oe_ni` is the one exception: the bench moves it between edges on purpose, to show that the enable responds without a clock.

// File: rtl/sburst_pkg.sv
package sburst_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_DESEL,
    CYC_START,
    CYC_NEXT,
    CYC_HOLD
  } cyc_e;
endpackage

// File: rtl/sburst_decode.sv
module sburst_decode
  import sburst_pkg::*;
#(
  parameter int NB = 2
) (
  input  logic          awake_i,
  input  logic          burst_act_i,
  input  logic          ce1_ni,
  input  logic          ce2_i,
  input  logic          ce3_ni,
  input  logic          cpu_ni,
  input  logic          ctl_ni,
  input  logic          adv_ni,
  input  logic          gw_ni,
  input  logic          bwe_ni,
  input  logic [NB-1:0] bw_ni,
  output cyc_e          cyc_o,
  output logic          wr_o,
  output logic [NB-1:0] mask_o
);
  logic ce_ok, wreq;
  cyc_e follow;

  always_comb begin
    ce_ok  = ce2_i & ~ce3_ni;
    wreq   = ~gw_ni | (~bwe_ni & ~(&bw_ni));
    follow = burst_act_i ? (adv_ni ? CYC_HOLD : CYC_NEXT) : CYC_IDLE;
    if (!awake_i)                cyc_o = CYC_IDLE;
    else if (ce1_ni)             cyc_o = ctl_ni ? follow : CYC_DESEL; // cpu strobe ignored
    else if (!cpu_ni || !ctl_ni) cyc_o = ce_ok ? CYC_START : CYC_DESEL;
    else                         cyc_o = follow;
    // processor-strobe start is always a read
    wr_o = wreq & ((cyc_o == CYC_NEXT) | (cyc_o == CYC_HOLD) |
                   ((cyc_o == CYC_START) & cpu_ni));
    if (!gw_ni)       mask_o = '1;
    else if (!bwe_ni) mask_o = ~bw_ni;
    else              mask_o = '0;
  end
endmodule

// File: rtl/sburst_cnt.sv
module sburst_cnt
  import sburst_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cyc_e          cyc_i,
  input  logic          abandon_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] acc_addr_o,
  output logic [AW-1:0] cur_addr_o,
  output logic          burst_act_o
);
  localparam int CW = 2;

  logic [AW-1:0] cur_q;
  logic          act_q;
  logic [CW-1:0] nxt_lo;

  assign nxt_lo      = cur_q[CW-1:0] + CW'(1);
  assign cur_addr_o  = cur_q;
  assign burst_act_o = act_q;

  always_comb begin
    case (cyc_i)
      CYC_START: acc_addr_o = addr_i;
      CYC_NEXT:  acc_addr_o = {cur_q[AW-1:CW], nxt_lo};
      default:   acc_addr_o = cur_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      act_q <= 1'b0;
    end else if (abandon_i) begin
      act_q <= 1'b0;
    end else begin
      case (cyc_i)
        CYC_START: begin cur_q <= addr_i; act_q <= 1'b1; end
        CYC_NEXT:  cur_q <= acc_addr_o;
        CYC_DESEL: act_q <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sburst_sleep.sv
module sburst_sleep #(
  parameter int REC_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_i,
  output logic awake_o
);
  localparam int RW = $clog2(REC_CYC + 1);

  logic [RW-1:0] rec_q;

  assign awake_o = ~sleep_i & (rec_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           rec_q <= '0;
    else if (sleep_i)      rec_q <= RW'(REC_CYC);
    else if (rec_q != '0)  rec_q <= rec_q - RW'(1);
  end
endmodule

// File: rtl/sburst_array.sv
module sburst_array #(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             we_i,
  input  logic [DW/BW-1:0] mask_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o
);
  localparam int NB    = DW / BW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] bit_mask;
  logic [DW-1:0] rdata_q;

  for (genvar b = 0; b < NB; b++) begin : g_mask
    assign bit_mask[b*BW +: BW] = {BW{mask_i[b]}};
  end

  always_ff @(posedge clk_i) begin
    if (en_i && we_i)
      mem[addr_i] <= (mem[addr_i] & ~bit_mask) | (wdata_i & bit_mask);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rdata_q <= '0;
    else if (en_i && !we_i)  rdata_q <= mem[addr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/sburst_ctrl.sv
module sburst_ctrl
  import sburst_pkg::*;
#(
  parameter int AW      = 6,
  parameter int DW      = 16,
  parameter int BW      = 8,
  parameter int REC_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce1_ni,
  input  logic             ce2_i,
  input  logic             ce3_ni,
  input  logic             strb_cpu_ni,
  input  logic             strb_ctl_ni,
  input  logic             adv_ni,
  input  logic             gw_ni,
  input  logic             bwe_ni,
  input  logic [DW/BW-1:0] bw_ni,
  input  logic             sleep_i,
  input  logic             oe_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             data_oe_o
);
  localparam int NB = DW / BW;

  logic          awake, burst_act, wr, arr_en, arr_we, rd_q;
  cyc_e          cyc;
  logic [NB-1:0] arr_mask;
  logic [AW-1:0] acc_addr, cur_addr;

  sburst_sleep #(.REC_CYC(REC_CYC)) u_sleep (
    .clk_i, .rst_ni, .sleep_i, .awake_o(awake)
  );

  sburst_decode #(.NB(NB)) u_dec (
    .awake_i(awake), .burst_act_i(burst_act), .ce1_ni, .ce2_i, .ce3_ni,
    .cpu_ni(strb_cpu_ni), .ctl_ni(strb_ctl_ni), .adv_ni, .gw_ni, .bwe_ni,
    .bw_ni, .cyc_o(cyc), .wr_o(wr), .mask_o(arr_mask)
  );

  sburst_cnt #(.AW(AW)) u_cnt (
    .clk_i, .rst_ni, .cyc_i(cyc), .abandon_i(sleep_i), .addr_i,
    .acc_addr_o(acc_addr), .cur_addr_o(cur_addr), .burst_act_o(burst_act)
  );

  assign arr_en = (cyc == CYC_START) | (cyc == CYC_NEXT) | (cyc == CYC_HOLD);
  assign arr_we = arr_en & wr;

  sburst_array #(.AW(AW), .DW(DW), .BW(BW)) u_arr (
    .clk_i, .rst_ni, .en_i(arr_en), .we_i(arr_we), .mask_i(arr_mask),
    .addr_i(acc_addr), .wdata_i, .rdata_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= 1'b0;
    else         rd_q <= arr_en & ~arr_we;
  end

  // output enable is unclocked; masked by write/deselect via rd_q
  assign data_oe_o = rd_q & ~oe_ni & ~sleep_i;
endmodule

// File: rtl/sburst_ctrl_chk.sv
module sburst_ctrl_chk
  import sburst_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sleep_i,
  input logic          oe_ni,
  input logic          ce1_ni,
  input logic          ce2_i,
  input logic          ce3_ni,
  input logic          strb_cpu_ni,
  input logic          strb_ctl_ni,
  input logic          awake,
  input logic          burst_act,
  input cyc_e          cyc,
  input logic          arr_en,
  input logic          arr_we,
  input logic [NB-1:0] arr_mask,
  input logic [AW-1:0] cur_addr,
  input logic          data_oe_o
);
  logic [1:0] cur_lo;
  assign cur_lo = cur_addr[1:0];

  assert_wr_mask_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we |-> (arr_mask != '0));

  assert_ce1_desel_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (awake && ce1_ni && !strb_ctl_ni) |=> (!burst_act && !data_oe_o));

  assert_cpu_desel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (awake && !ce1_ni && !strb_cpu_ni && (!ce2_i || ce3_ni)) |-> !arr_en);

  assert_cpu_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (awake && !ce1_ni && !strb_cpu_ni) |-> !arr_we);

  assert_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == CYC_NEXT) |=> (cur_lo == $past(cur_lo) + 2'd1));

  assert_upper_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == CYC_NEXT) |=> $stable(cur_addr[AW-1:2]));

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == CYC_HOLD) |=> $stable(cur_addr));

  assert_oe_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!oe_ni && $past(arr_en && !arr_we)));

  assert_sleep_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> (!data_oe_o && !arr_en));

  assert_rec_first_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sleep_i) |-> !arr_en);

  assert_rec_second_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sleep_i) |=> !arr_en);

  assert_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!burst_act && strb_ctl_ni && (strb_cpu_ni || ce1_ni)) |-> !arr_en);
endmodule

bind sburst_ctrl sburst_ctrl_chk #(.AW(AW), .NB(NB)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sleep_i(sleep_i), .oe_ni(oe_ni),
  .ce1_ni(ce1_ni), .ce2_i(ce2_i), .ce3_ni(ce3_ni),
  .strb_cpu_ni(strb_cpu_ni), .strb_ctl_ni(strb_ctl_ni),
  .awake(awake), .burst_act(burst_act), .cyc(cyc), .arr_en(arr_en),
  .arr_we(arr_we), .arr_mask(arr_mask), .cur_addr(cur_addr),
  .data_oe_o(data_oe_o)
);

// File: tb/sburst_ctrl_tb.sv
module sburst_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int NB = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce1_n, ce2, ce3_n, cpu_n, ctl_n, adv_n, gw_n, bwe_n, slp, oe_n;
  logic [NB-1:0] bw_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic doe;

  logic [DW-1:0] mem_m [1<<AW];
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sburst_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ce1_ni(ce1_n), .ce2_i(ce2), .ce3_ni(ce3_n),
    .strb_cpu_ni(cpu_n), .strb_ctl_ni(ctl_n), .adv_ni(adv_n), .gw_ni(gw_n),
    .bwe_ni(bwe_n), .bw_ni(bw_n), .sleep_i(slp), .oe_ni(oe_n), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .data_oe_o(doe)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic exp_read(input string tag, input logic [AW-1:0] a);
    chk(doe === 1'b1, tag, 32'(doe), 32'd1);
    chk(rdata === mem_m[a], tag, 32'(rdata), 32'(mem_m[a]));
  endtask

  task automatic exp_quiet(input string tag);
    chk(doe === 1'b0, tag, 32'(doe), 32'd0);
  endtask

  task automatic set_idle();
    ce1_n = 1; ce2 = 1; ce3_n = 0; cpu_n = 1; ctl_n = 1; adv_n = 1;
    gw_n = 1; bwe_n = 1; bw_n = '1; slp = 0; addr = '0; wdata = '0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic ctl_op(input logic [AW-1:0] a, input logic g, input logic be,
                        input logic [NB-1:0] bw, input logic [DW-1:0] d);
    set_idle(); ce1_n = 0; ctl_n = 0; addr = a; gw_n = g; bwe_n = be;
    bw_n = bw; wdata = d;
    step();
  endtask

  task automatic ctl_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    ctl_op(a, 1'b0, 1'b1, '1, d);
    mem_m[a] = d;
  endtask

  task automatic ctl_read(input logic [AW-1:0] a);
    ctl_op(a, 1'b1, 1'b1, '1, '0);
  endtask

  task automatic nxt(input logic adv, input logic g, input logic [DW-1:0] d);
    set_idle(); adv_n = adv; gw_n = g; wdata = d;
    step();
  endtask

  task automatic desel();
    set_idle(); ctl_n = 0;
    step();
  endtask

  task automatic t_reset();
    exp_quiet("R11 reset oe");
    nxt(1'b0, 1'b1, '0);
    exp_quiet("R10 continue without burst");
    nxt(1'b1, 1'b1, '0);
    exp_quiet("R10 suspend without burst");
  endtask

  task automatic t_wreq();
    ctl_write(6'h05, 16'hA5C3);
    exp_quiet("R1 full write no drive");
    ctl_op(6'h05, 1'b1, 1'b0, 2'b10, 16'h1122);
    mem_m[5][7:0] = 8'h22;
    exp_quiet("R1 byte0 write");
    ctl_op(6'h05, 1'b1, 1'b0, 2'b11, 16'hFFFF);
    exp_read("R1 bwe low no bytes is read", 6'h05);
    ctl_op(6'h05, 1'b1, 1'b1, 2'b00, 16'hFFFF);
    exp_read("R1 bwe high is read", 6'h05);
    ctl_op(6'h05, 1'b1, 1'b0, 2'b01, 16'h7700);
    mem_m[5][15:8] = 8'h77;
    ctl_read(6'h05);
    exp_read("R1 byte1 merge", 6'h05);
    desel();
  endtask

  task automatic t_ctl_invalid();
    set_idle(); ce1_n = 0; ce2 = 0; ctl_n = 0; gw_n = 0; addr = 6'h05;
    wdata = 16'hDEAD;
    step();
    exp_quiet("R5 ce2 low deselect");
    nxt(1'b1, 1'b1, '0);
    exp_quiet("R5 no burst after invalid start");
    set_idle(); ce1_n = 0; ce3_n = 1; ctl_n = 0; gw_n = 0; addr = 6'h05;
    wdata = 16'hBEEF;
    step();
    exp_quiet("R5 ce3 high deselect");
    ctl_read(6'h05);
    exp_read("R5 memory untouched", 6'h05);
    desel();
  endtask

  task automatic t_cpu();
    set_idle(); ce1_n = 0; cpu_n = 0; addr = 6'h05; gw_n = 0; wdata = 16'h0000;
    step();
    exp_read("R4 cpu start forced read", 6'h05);
    nxt(1'b1, 1'b0, 16'h3333);
    mem_m[5] = 16'h3333;
    exp_quiet("R4 write after cpu start");
    nxt(1'b1, 1'b1, '0);
    exp_read("R4 follow-on write landed", 6'h05);
    desel();
  endtask

  task automatic t_cpu_desel();
    ctl_read(6'h05);
    exp_read("R3 pre burst", 6'h05);
    set_idle(); ce1_n = 0; cpu_n = 0; ce2 = 0; addr = 6'h05;
    step();
    exp_quiet("R3 ce2 low deselect");
    nxt(1'b1, 1'b1, '0);
    exp_quiet("R3 burst ended");
    ctl_read(6'h05);
    set_idle(); ce1_n = 0; cpu_n = 0; ce3_n = 1; addr = 6'h05;
    step();
    exp_quiet("R3 ce3 high deselect");
    nxt(1'b1, 1'b1, '0);
    exp_quiet("R3 burst ended ce3");
  endtask

  task automatic t_ce1();
    ctl_write(6'h30, 16'h0A0A);
    ctl_write(6'h31, 16'h0B0B);
    ctl_read(6'h30);
    set_idle(); cpu_n = 0; addr = 6'h31;
    step();
    exp_read("R2 cpu strobe ignored", 6'h30);
    desel();
    exp_quiet("R2 ctl deselect");
    nxt(1'b0, 1'b1, '0);
    exp_quiet("R2 burst ended");
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 4; i++) ctl_write(6'(12 + i), 16'hC000 + 16'(i));
    ctl_read(6'h0E);
    exp_read("R6 start 0E", 6'h0E);
    nxt(1'b0, 1'b1, '0); exp_read("R6 0F", 6'h0F);
    nxt(1'b0, 1'b1, '0); exp_read("R6 wrap 0C", 6'h0C);
    nxt(1'b0, 1'b1, '0); exp_read("R6 0D", 6'h0D);
    nxt(1'b0, 1'b1, '0); exp_read("R6 0E again", 6'h0E);
    ctl_write(6'h12, 16'h1200);
    nxt(1'b0, 1'b0, 16'h1300); mem_m[6'h13] = 16'h1300;
    nxt(1'b0, 1'b0, 16'h1000); mem_m[6'h10] = 16'h1000;
    nxt(1'b0, 1'b0, 16'h1100); mem_m[6'h11] = 16'h1100;
    exp_quiet("R6 burst write no drive");
    for (int i = 0; i < 4; i++) begin
      ctl_read(6'(16 + i));
      exp_read("R6 burst write readback", 6'(16 + i));
    end
    ctl_read(6'h14);
    chk(rdata !== 16'h1000, "R6 upper bits kept", 32'(rdata), 32'h1000);
    desel();
  endtask

  task automatic t_suspend();
    ctl_read(6'h0D);
    nxt(1'b1, 1'b1, '0); exp_read("R7 hold 0D", 6'h0D);
    nxt(1'b1, 1'b1, '0); exp_read("R7 hold 0D twice", 6'h0D);
    nxt(1'b0, 1'b1, '0); exp_read("R7 then advance 0E", 6'h0E);
    desel();
  endtask

  task automatic t_oe();
    set_idle(); ce1_n = 0; ctl_n = 0; addr = 6'h0C;
    #1;
    exp_quiet("R8 not before edge");
    step();
    exp_read("R8 read after edge", 6'h0C);
    oe_n = 1; #1;
    exp_quiet("R8 oe high releases");
    oe_n = 0; #1;
    chk(doe === 1'b1, "R8 oe low drives", 32'(doe), 32'd1);
    nxt(1'b1, 1'b0, 16'h5A5A); mem_m[6'h0C] = 16'h5A5A;
    exp_quiet("R8 write masks oe");
    desel();
  endtask

  task automatic t_sleep();
    ctl_read(6'h0C);
    set_idle(); slp = 1; ce1_n = 0; ctl_n = 0; gw_n = 0; addr = 6'h0C;
    wdata = 16'hBAD0;
    #1;
    exp_quiet("R9 sleep releases bus at once");
    step();
    exp_quiet("R9 sleeping");
    step();
    slp = 0;
    ce1_n = 0; ctl_n = 0; gw_n = 1; addr = 6'h0C;
    step();
    exp_quiet("R9 first edge after wake ignored");
    step();
    exp_quiet("R9 second edge after wake ignored");
    step();
    exp_read("R9 third edge accepted, write in sleep ignored", 6'h0C);
    ctl_read(6'h0D);
    set_idle(); slp = 1;
    step();
    set_idle();
    step(); step();
    nxt(1'b1, 1'b1, '0);
    exp_quiet("R9 R10 burst abandoned by sleep");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    oe_n = 0;
    set_idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_wreq();
    t_ctl_invalid();
    t_cpu();
    t_cpu_desel();
    t_ce1();
    t_wrap();
    t_suspend();
    t_oe();
    t_sleep();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule